// File: doc/BRIEF.md
# Multiprocessor UART with Station Address Filtering

This block is a full-duplex asynchronous serial transceiver. It runs from the peripheral clock and uses 16x oversampling, with a programmable 16-bit divisor that sets the bit time. The transmit and receive halves run independently and can work at the same time. The transmit half turns a parallel character into a frame with one low start bit, data LSB first and a high stop bit. The receive half rebuilds characters from the incoming line, which it first synchronises to the clock.

Two character formats are supported. In the plain format a frame carries 8 data bits. In the multiprocessor format a frame carries a ninth bit, which marks the character as a station address (1) or as data (0). In the multiprocessor format the receiver never passes address characters to the host. It uses them only to decide whether it is selected: it becomes selected when an address equal to its programmed station address arrives, and deselected when any other address arrives. Data characters reach the host only while the receiver is selected.

The host side is a single holding register in each direction. The transmit side uses a write strobe and a ready flag. The receive side offers a one-cycle valid pulse, a full flag cleared by a read strobe, and two sticky error flags.

Top module: `mp_uart`

## Requirements
- R1: Out of reset, txd is high, tx_ready is 1, and rx_valid, rx_full, framing_err and overrun_err are all 0. The receiver is not selected.
- R2: One bit lasts 16*N clock cycles, where N is the value of divisor, and a divisor of 0 behaves as 1. Transmitting the character 0x00 in the plain format therefore holds txd low for exactly 9*16*N cycles.
- R3: A transmitted frame is one start bit at 0, then the data bits LSB first, then, in the multiprocessor format only (mp_mode=1), the tx_addr_flag bit, then one stop bit at 1. Between frames the line is held at 1.
- R4: tx_ready is 1 only while both the holding register and the shift register are empty. It drops in the cycle after an accepted tx_write. A tx_write while tx_ready is 0 is ignored and produces no frame.
- R5: A received frame with a valid stop bit loads its data into rx_data, raises rx_valid for one cycle and sets rx_full. This applies in the plain format, and in the multiprocessor format while the receiver is selected.
- R6: If rxd goes low but reads high at the midpoint of the start bit, the event is a glitch. It is discarded and nothing is delivered.
- R7: A stop bit sampled at 0 sets the sticky flag framing_err, and that character is not delivered.
- R8: If a character is delivered while rx_full is 1 and rx_read is not asserted in that cycle, the sticky flag overrun_err is set and rx_data takes the new character. rx_read clears rx_full.
- R9: In the multiprocessor format, a character whose ninth bit is 1 is never delivered. It selects the receiver if its 8 data bits equal station_addr and deselects it otherwise. A character whose ninth bit is 0 is delivered only while the receiver is selected.
- R10: A one-cycle err_clear pulse clears both framing_err and overrun_err.
- R11: A frame can be transmitted and another received at the same time without either one corrupting the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Oversampling divisor (0 acts as 1) |
| mp_mode | input | 1 | 1 selects the 9-bit multiprocessor format |
| station_addr | input | 8 | Local station address |
| tx_data | input | 8 | Character to transmit |
| tx_addr_flag | input | 1 | Ninth bit sent in the multiprocessor format |
| tx_write | input | 1 | Write strobe for the transmit holding register |
| tx_ready | output | 1 | Transmitter fully empty |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Last delivered character |
| rx_valid | output | 1 | One-cycle pulse on delivery |
| rx_full | output | 1 | Unread character present |
| rx_read | input | 1 | Clears rx_full |
| framing_err | output | 1 | Sticky bad-stop-bit flag |
| overrun_err | output | 1 | Sticky overrun flag |
| err_clear | input | 1 | Clears both sticky flags |

## Verification
tx_ready falls one clock after the write is accepted, and the bench samples it at the next falling edge. rx_valid arrives one clock after the oversampling tick at the stop-bit midpoint, up to two synchroniser cycles and one tick period after the real line midpoint. Each receive check therefore waits for the whole stop bit plus a further bit time of idle line, and then compares a delivery counter and the captured data. Transmit checks find the falling edge of txd at a falling clock edge and sample every later bit at its midpoint, counting in bit times. The low time for R2 is counted exactly, cycle by cycle, at falling edges.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int OSR = 16;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/mpu_baud.sv
module mpu_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] eff;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    eff   = (divisor == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : divisor;
    tick  = (cnt_q >= eff - 1'b1);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor > 1) |=> (!tick || divisor <= 1));
endmodule

// File: rtl/mpu_tx.sv
module mpu_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mp_mode,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_flag,
  output logic              ready,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int BN_W    = $clog2(FRAME_W + 1);

  logic              hold_v_q, hold_v_d;
  logic [DATA_W:0]   hold_q, hold_d;
  logic              busy_q, busy_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [3:0]        sub_q, sub_d;
  logic [BN_W-1:0]   bn_q, bn_d, last_q, last_d;
  logic              accept;

  always_comb begin
    ready    = !hold_v_q && !busy_q;
    accept   = wr && ready;
    hold_v_d = hold_v_q;
    hold_d   = hold_q;
    busy_d   = busy_q;
    sh_d     = sh_q;
    sub_d    = sub_q;
    bn_d     = bn_q;
    last_d   = last_q;
    if (accept) begin
      hold_v_d = 1'b1;
      hold_d   = {wr_flag, wr_data};
    end
    if (tick && !busy_q && hold_v_q) begin
      busy_d   = 1'b1;
      hold_v_d = 1'b0;
      sub_d    = '0;
      bn_d     = '0;
      if (mp_mode) begin
        sh_d   = {1'b1, hold_q[DATA_W], hold_q[DATA_W-1:0], 1'b0};
        last_d = BN_W'(FRAME_W - 1);
      end else begin
        sh_d   = {2'b11, hold_q[DATA_W-1:0], 1'b0};
        last_d = BN_W'(FRAME_W - 2);
      end
    end else if (tick && busy_q) begin
      sub_d = sub_q + 1'b1;
      if (sub_q == 4'd15) begin
        sh_d = {1'b1, sh_q[FRAME_W-1:1]};
        bn_d = bn_q + 1'b1;
        if (bn_q == last_q) busy_d = 1'b0;
      end
    end
    txd = busy_q ? sh_q[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      busy_q   <= 1'b0;
      sh_q     <= '1;
      sub_q    <= '0;
      bn_q     <= '0;
      last_q   <= '0;
    end else begin
      hold_v_q <= hold_v_d;
      hold_q   <= hold_d;
      busy_q   <= busy_d;
      sh_q     <= sh_d;
      sub_q    <= sub_d;
      bn_q     <= bn_d;
      last_q   <= last_d;
    end
  end

  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd);
endmodule

// File: rtl/mpu_rx.sv
module mpu_rx
  import mpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              mp_mode,
  input  logic [DATA_W-1:0] station_addr,
  input  logic              rd,
  input  logic              err_clear,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_full,
  output logic              ferr,
  output logic              ovr
);
  localparam int BN_W = $clog2(DATA_W + 1);

  logic            s1_q, s2_q;
  rx_state_t       st_q, st_d;
  logic [3:0]      sub_q, sub_d;
  logic [BN_W-1:0] bn_q, bn_d;
  logic [DATA_W:0] sh_q, sh_d;
  logic            mode_q, mode_d;
  logic            sel_q, sel_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic            valid_q, valid_d, full_q, full_d, ferr_q, ferr_d, ovr_q, ovr_d;
  logic            done, stop_ok, is_addr, deliver;
  logic [DATA_W-1:0] chr;
  logic [BN_W-1:0] last;

  always_comb begin
    st_d    = st_q;
    sub_d   = sub_q;
    bn_d    = bn_q;
    sh_d    = sh_q;
    mode_d  = mode_q;
    done    = 1'b0;
    last    = mode_q ? BN_W'(DATA_W) : BN_W'(DATA_W - 1);
    case (st_q)
      RX_IDLE: if (tick && !s2_q) begin
        st_d  = RX_START;
        sub_d = '0;
      end
      RX_START: if (tick) begin
        if (sub_q == 4'd7) begin
          if (!s2_q) begin
            st_d   = RX_DATA;
            sub_d  = '0;
            bn_d   = '0;
            mode_d = mp_mode;
          end else begin
            st_d = RX_IDLE;
          end
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
      RX_DATA: if (tick) begin
        sub_d = sub_q + 1'b1;
        if (sub_q == 4'd15) begin
          sh_d = {s2_q, sh_q[DATA_W:1]};
          bn_d = bn_q + 1'b1;
          if (bn_q == last) st_d = RX_STOP;
        end
      end
      RX_STOP: if (tick) begin
        sub_d = sub_q + 1'b1;
        if (sub_q == 4'd15) begin
          done = 1'b1;
          st_d = RX_IDLE;
        end
      end
      default: st_d = RX_IDLE;
    endcase

    stop_ok = s2_q;
    chr     = mode_q ? sh_q[DATA_W-1:0] : sh_q[DATA_W:1];
    is_addr = mode_q && sh_q[DATA_W];
    deliver = done && stop_ok && !is_addr && (!mode_q || sel_q);

    sel_d   = sel_q;
    if (done && stop_ok && is_addr) sel_d = (chr == station_addr);

    valid_d = deliver;
    data_d  = deliver ? chr : data_q;
    full_d  = deliver ? 1'b1 : (rd ? 1'b0 : full_q);
    ovr_d   = (ovr_q && !err_clear) || (deliver && full_q && !rd);
    ferr_d  = (ferr_q && !err_clear) || (done && !stop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      st_q    <= RX_IDLE;
      sub_q   <= '0;
      bn_q    <= '0;
      sh_q    <= '0;
      mode_q  <= 1'b0;
      sel_q   <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      full_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      s1_q    <= rxd;
      s2_q    <= s1_q;
      st_q    <= st_d;
      sub_q   <= sub_d;
      bn_q    <= bn_d;
      sh_q    <= sh_d;
      mode_q  <= mode_d;
      sel_q   <= sel_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      full_q  <= full_d;
      ferr_q  <= ferr_d;
      ovr_q   <= ovr_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = valid_q;
  assign rx_full  = full_q;
  assign ferr     = ferr_q;
  assign ovr      = ovr_q;

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_valid_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_full);
  p_ferr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr && !err_clear) |=> ferr);
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !err_clear) |=> ovr);
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (!rx_full || rx_valid));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !done) |=> !ferr);
endmodule

// File: rtl/mp_uart.sv
module mp_uart #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              mp_mode,
  input  logic [DATA_W-1:0] station_addr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_addr_flag,
  input  logic              tx_write,
  output logic              tx_ready,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_full,
  input  logic              rx_read,
  output logic              framing_err,
  output logic              overrun_err,
  input  logic              err_clear
);
  logic tick;

  mpu_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
  );

  mpu_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mp_mode(mp_mode),
    .wr(tx_write), .wr_data(tx_data), .wr_flag(tx_addr_flag),
    .ready(tx_ready), .txd(txd)
  );

  mpu_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .mp_mode(mp_mode),
    .station_addr(station_addr), .rd(rx_read), .err_clear(err_clear),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_full(rx_full),
    .ferr(framing_err), .ovr(overrun_err)
  );

  p_idle_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);
endmodule

// File: tb/test_mp_uart.sv
`timescale 1ns/1ps
module test_mp_uart;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] divisor;
  logic        mp_mode;
  logic [7:0]  station_addr;
  logic [7:0]  tx_data;
  logic        tx_addr_flag;
  logic        tx_write;
  logic        tx_ready;
  logic        txd;
  logic        rxd;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        rx_full;
  logic        rx_read;
  logic        framing_err;
  logic        overrun_err;
  logic        err_clear;

  int tests = 0;
  int fails = 0;
  int vcount = 0;
  logic [7:0] vlast = '0;
  int bitc = 32;

  always #4 clk = ~clk;

  mp_uart i_mp_uart (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .mp_mode(mp_mode),
    .station_addr(station_addr), .tx_data(tx_data), .tx_addr_flag(tx_addr_flag),
    .tx_write(tx_write), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_full(rx_full), .rx_read(rx_read),
    .framing_err(framing_err), .overrun_err(overrun_err), .err_clear(err_clear)
  );

  always @(negedge clk) if (rx_valid) begin
    vcount = vcount + 1;
    vlast  = rx_data;
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_read();
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic ninth,
                          input logic use9, input logic stop_ok);
    @(negedge clk);
    rxd = 1'b0; repeat (bitc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i]; repeat (bitc) @(negedge clk);
    end
    if (use9) begin
      rxd = ninth; repeat (bitc) @(negedge clk);
    end
    if (stop_ok) begin
      rxd = 1'b1; repeat (bitc) @(negedge clk);
    end else begin
      rxd = 1'b0; repeat (bitc*3/4) @(negedge clk);
      rxd = 1'b1; repeat (bitc/4) @(negedge clk);
    end
    repeat (bitc) @(negedge clk);
  endtask

  task automatic tx_write_chr(input logic [7:0] d, input logic flag);
    @(negedge clk);
    tx_data = d; tx_addr_flag = flag; tx_write = 1'b1;
    @(negedge clk);
    tx_write = 1'b0;
  endtask

  task automatic tx_decode(input int nb, output logic [9:0] bits);
    int guard = 0;
    bits = '0;
    while (txd && guard < 20000) begin @(negedge clk); guard++; end
    repeat (bitc/2) @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < nb; i++) begin
      repeat (bitc) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  task automatic t_reset();
    chk("R1 txd", int'(txd), 1);
    chk("R1 tx_ready", int'(tx_ready), 1);
    chk("R1 rx_valid/rx_full", int'({rx_valid, rx_full}), 0);
    chk("R1 error flags", int'({framing_err, overrun_err}), 0);
  endtask

  task automatic t_rx_plain();
    int v0 = vcount;
    rx_frame(8'hA5, 1'b0, 1'b0, 1'b1);
    chk("R5 delivered count", vcount - v0, 1);
    chk("R5 rx_data", int'(vlast), 'hA5);
    chk("R5 rx_full", int'(rx_full), 1);
    pulse_read();
    chk("R8 rx_read clears rx_full", int'(rx_full), 0);
    rx_frame(8'h3C, 1'b0, 1'b0, 1'b1);
    chk("R5 second rx_data", int'(rx_data), 'h3C);
    pulse_read();
  endtask

  task automatic t_glitch();
    int v0 = vcount;
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (bitc*12) @(negedge clk);
    chk("R6 glitch not delivered", vcount - v0, 0);
    chk("R6 rx_full unchanged", int'(rx_full), 0);
  endtask

  task automatic t_framing();
    int v0 = vcount;
    rx_frame(8'h5A, 1'b0, 1'b0, 1'b0);
    repeat (bitc*2) @(negedge clk);
    chk("R7 framing_err set", int'(framing_err), 1);
    chk("R7 char dropped", vcount - v0, 0);
    pulse_clear();
    chk("R10 framing_err cleared", int'(framing_err), 0);
  endtask

  task automatic t_overrun();
    rx_frame(8'h11, 1'b0, 1'b0, 1'b1);
    chk("R8 no overrun on first", int'(overrun_err), 0);
    rx_frame(8'h22, 1'b0, 1'b0, 1'b1);
    chk("R8 overrun_err set", int'(overrun_err), 1);
    chk("R8 rx_data replaced", int'(rx_data), 'h22);
    pulse_read();
    pulse_clear();
    chk("R10 overrun_err cleared", int'(overrun_err), 0);
  endtask

  task automatic t_multiproc();
    int v0;
    mp_mode = 1'b1; station_addr = 8'h42;
    v0 = vcount;
    rx_frame(8'h11, 1'b0, 1'b1, 1'b1);
    chk("R9 data before select dropped", vcount - v0, 0);
    rx_frame(8'h42, 1'b1, 1'b1, 1'b1);
    chk("R9 matching address not delivered", vcount - v0, 0);
    rx_frame(8'h55, 1'b0, 1'b1, 1'b1);
    chk("R9 data while selected", vcount - v0, 1);
    chk("R9 selected data value", int'(vlast), 'h55);
    pulse_read();
    rx_frame(8'h17, 1'b1, 1'b1, 1'b1);
    rx_frame(8'h66, 1'b0, 1'b1, 1'b1);
    chk("R9 data after other address dropped", vcount - v0, 1);
    mp_mode = 1'b0;
  endtask

  task automatic t_tx_frames();
    logic [9:0] b;
    fork
      tx_write_chr(8'hC3, 1'b0);
      tx_decode(10, b);
    join
    chk("R3 plain start bit", int'(b[0]), 0);
    chk("R3 plain data LSB first", int'(b[8:1]), 'hC3);
    chk("R3 plain stop bit", int'(b[9]), 1);
    repeat (bitc) @(negedge clk);
    mp_mode = 1'b1;
    fork
      tx_write_chr(8'h5A, 1'b1);
      tx_decode(10, b);
    join
    chk("R3 mp data", int'(b[8:1]), 'h5A);
    chk("R3 mp ninth bit", int'(b[9]), 1);
    repeat (bitc*2) @(negedge clk);
    chk("R3 mp stop then idle high", int'(txd), 1);
    mp_mode = 1'b0;
  endtask

  task automatic t_ready();
    logic [9:0] b;
    int falls = 0;
    logic prev;
    tx_write_chr(8'h81, 1'b0);
    chk("R4 tx_ready low after write", int'(tx_ready), 0);
    repeat (3) @(negedge clk);
    tx_write_chr(8'h7E, 1'b0);
    tx_decode(10, b);
    chk("R4 first frame kept", int'(b[8:1]), 'h81);
    repeat (bitc) @(negedge clk);
    chk("R4 tx_ready back", int'(tx_ready), 1);
    prev = txd;
    repeat (bitc*24) begin
      @(negedge clk);
      if (prev && !txd) falls++;
      prev = txd;
    end
    chk("R4 ignored write made no frame", falls, 0);
  endtask

  task automatic t_baud(input logic [15:0] dv, input int expect_low);
    int n = 0;
    divisor = dv;
    bitc = 16 * ((dv == 0) ? 1 : int'(dv));
    repeat (4) @(negedge clk);
    tx_write_chr(8'h00, 1'b0);
    while (txd) @(negedge clk);
    while (!txd && n < 100000) begin n++; @(negedge clk); end
    chk("R2 low time for 0x00", n, expect_low);
    repeat (bitc*2) @(negedge clk);
  endtask

  task automatic t_duplex();
    logic [9:0] b;
    int v0 = vcount;
    fork
      rx_frame(8'h96, 1'b0, 1'b0, 1'b1);
      begin
        tx_write_chr(8'h69, 1'b0);
        tx_decode(10, b);
      end
    join
    chk("R11 rx during tx", int'(vlast), 'h96);
    chk("R11 rx count", vcount - v0, 1);
    chk("R11 tx during rx", int'(b[8:1]), 'h69);
    pulse_read();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; divisor = 16'd2; mp_mode = 1'b0; station_addr = 8'h00;
    tx_data = '0; tx_addr_flag = 1'b0; tx_write = 1'b0; rxd = 1'b1;
    rx_read = 1'b0; err_clear = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_plain();
    t_glitch();
    t_framing();
    t_overrun();
    t_multiproc();
    t_tx_frames();
    t_ready();
    t_duplex();
    t_baud(16'd0, 144);
    t_baud(16'd3, 432);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule